// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Model

This block is a cycle-accurate, synthesizable model of a quad-data-rate static memory. The memory has a separate read port and a separate write port. Every transfer is a burst of four words. The model runs on a single clock at twice the device's K rate, so each rising edge of `clk` stands for one half-period. Edges alternate between the K rise and the K# rise. The `k_phase` output is high when the next rising edge is a K rise. A testbench or a surrounding model uses it to line up its stimulus.

A request is taken only on a K rise. The read and write selects are active-low, and both ports share one address bus. A write stores four words from the data bus on the next four half-period edges, starting one full K period after the request. A read drives its four words starting two and a half K periods after the request.

Burst addresses count through the two low address bits and wrap inside an aligned group of four. A second request on a port at the K rise right after an accepted one is dropped. Byte lanes of each write beat are qualified by active-low byte selects. The read output is modelled as a value plus a drive flag; an undriven bus reads as zero.

Top module: `qdr4_burst_sram`

## Requirements
- R1: A write accepted at K rise h0 (half-period edge index 0) stores the wdata presented at edges h2, h3, h4 and h5 into burst words 0, 1, 2 and 3.
- R2: A read accepted at edge h0 sets rdata_drive high during the four half-periods that follow edges h5, h6, h7 and h8, carrying burst words 0 to 3 in that order. rdata_drive is low after edge h4 and after edge h9 unless another burst is running.
- R3: Burst word i of a request at address A goes to address {A[AW-1:2], (A[1:0]+i) mod 4}, so A=6 visits 6, 7, 4, 5.
- R4: During a write beat, byte lane L (bits [8L+7:8L]) is stored only when byte_wr_n[L] is 0 at that beat's edge. Lanes with byte_wr_n[L]=1 keep their old contents.
- R5: A request at the K rise directly after an accepted request on the same port is ignored. The request at the K rise after that is accepted again.
- R6: After synchronous reset, rdata_drive is 0, rdata is 0, and k_phase is 1, so the first edge after reset release is a K rise.
- R7: With both selects high, no array word changes, whatever the write data, and rdata_drive stays 0.
- R8: A select that is low only at a K# rise (k_phase was 0) starts no transfer.
- R9: A read and a write accepted at the same K rise are both carried out. The read returns the array contents as they stood at the edge where it was accepted, so overlapping words come back with their old values.
- R10: Whenever rdata_drive is 0, rdata is 0.
- R11: Reads accepted on every other K rise produce an unbroken run of driven beats, with no idle half-period between bursts.
- R12: k_phase toggles on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period clock, two edges per K period |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled on K rises |
| wr_sel_n | input | 1 | Active-low write request, sampled on K rises |
| addr | input | AW | Shared burst start address |
| wdata | input | DW | Write data, one word per write beat |
| byte_wr_n | input | NB | Active-low per-lane write enables for each beat |
| rdata | output | DW | Read data, zero when not driven |
| rdata_drive | output | 1 | High while a read beat is on rdata |
| k_phase | output | 1 | High when the next clk edge is a K rise |

## Verification
The assertions take for granted that reset is held for at least one edge before any request. They also assume that the caller treats k_phase as the only reference for which edge is a K rise. The read-origin and write-origin properties look back a fixed number of edges to a select that was low while k_phase was high, so they rely on requests being presented as clean levels for a whole half-period.

The bench drives every input on the falling edge, after waiting for k_phase to show that a K rise comes next. It keeps the shared write-data bus owned by the accepted write during that write's four beats. It reads only addresses it has already filled.

// File: rtl/qdr4_pkg.sv
// Shared constants and types for the burst-of-four quad-data-rate memory model.
// Assumes bursts of four and a clock running at twice the K rate.
package qdr4_pkg;
    localparam int BURST_LEN     = 4;
    localparam int BEAT_W        = $clog2(BURST_LEN);
    localparam int WR_FIRST_HALF = 2;  // first write beat: K rise one period after the request
    localparam int RD_FIRST_HALF = 5;  // first read beat: K# rise two and a half periods later
    localparam int PORT_SLOTS    = 2;  // overlapping bursts per port
    typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/qdr4_phase_gen.sv
// Half-period phase tracker. k_next is high when the coming clk edge is a
// K rise. Assumes clk runs at twice the K rate and reset lands on a K boundary.
module qdr4_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic k_next
);
    // Alternate K and K# edges, starting with K after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) k_next <= 1'b1;
        else        k_next <= ~k_next;
    end
endmodule

// File: rtl/qdr4_req_gate.sv
// Request acceptance for one port. A request is taken on a K rise when its
// select is low, unless the same port accepted at the previous K rise.
// Assumes k_edge marks the edge that is a K rise.
module qdr4_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic k_edge,
    input  logic sel_n,
    output logic accept
);
    logic last_acc;

    assign accept = k_edge && !sel_n && !last_acc;

    // Remember whether the latest K rise accepted, for back-to-back suppression.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_acc <= 1'b0;
        else if (k_edge) last_acc <= accept;
    end
endmodule

// File: rtl/qdr4_burst_seq.sv
// Burst timing sequencer for one port. Each accepted request takes a slot
// that counts half-periods. The slot reports beats 0..3 on the edges
// FIRST_HALF..FIRST_HALF+3 after acceptance. Assumes accepted requests are at
// least four half-periods apart, so at most one slot is in its beat window.
module qdr4_burst_seq
    import qdr4_pkg::*;
#(
    parameter  int FIRST_HALF = 2,
    parameter  int SLOTS      = 2,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int LAST_HALF  = FIRST_HALF + BURST_LEN - 1,
    localparam int CNT_W      = $clog2(LAST_HALF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    output logic [SLOT_W-1:0] acc_slot,
    output logic              beat_vld,
    output logic [SLOT_W-1:0] beat_slot,
    output beat_t             beat_idx
);
    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(FIRST_HALF);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(LAST_HALF);

    logic [SLOTS-1:0] busy;
    logic [CNT_W-1:0] cnt [SLOTS];

    // Round-robin slot pointer, advanced on every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_slot <= '0;
        else if (accept)
            acc_slot <= (acc_slot == SLOT_W'(SLOTS - 1)) ? '0 : acc_slot + SLOT_W'(1);
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Start, advance and retire one burst timer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[s] <= 1'b0;
                cnt[s]  <= '0;
            end else if (accept && acc_slot == SLOT_W'(s)) begin
                busy[s] <= 1'b1;
                cnt[s]  <= CNT_W'(1);
            end else if (busy[s]) begin
                cnt[s] <= cnt[s] + CNT_W'(1);
                if (cnt[s] == LAST_C) busy[s] <= 1'b0;
            end
        end
    end

    // Pick the slot, if any, whose counter sits inside the beat window.
    always_comb begin
        beat_vld  = 1'b0;
        beat_slot = '0;
        beat_idx  = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (busy[s] && cnt[s] >= FIRST_C && cnt[s] <= LAST_C) begin
                beat_vld  = 1'b1;
                beat_slot = SLOT_W'(s);
                beat_idx  = BEAT_W'(cnt[s] - FIRST_C);
            end
        end
    end
endmodule

// File: rtl/qdr4_array.sv
// Storage array with the write path and a four-word read snapshot port.
// Keeps the start address of each write slot and applies byte-qualified
// beats with wrap inside the aligned group of four. The snapshot gives the
// four words of the group at snap_base as they are before the current edge.
// Assumes AW > 2 and DW divisible by NB.
module qdr4_array
    import qdr4_pkg::*;
#(
    parameter  int AW     = 4,
    parameter  int DW     = 16,
    parameter  int NB     = 2,
    parameter  int SLOTS  = 2,
    localparam int DEPTH  = 1 << AW,
    localparam int LANE_W = DW / NB,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                          clk,
    input  logic                          load,
    input  logic [SLOT_W-1:0]             load_slot,
    input  logic [AW-1:0]                 addr,
    input  logic                          beat_vld,
    input  logic [SLOT_W-1:0]             beat_slot,
    input  beat_t                         beat_idx,
    input  logic [DW-1:0]                 wdata,
    input  logic [NB-1:0]                 byte_wr_n,
    output logic [BURST_LEN-1:0][DW-1:0]  snap_words
);
    logic [AW-1:0] base [SLOTS];
    logic [DW-1:0] mem  [DEPTH];
    logic [AW-1:0] base_sel;
    logic [AW-1:0] waddr;

    // Capture the start address of a newly accepted write.
    always_ff @(posedge clk) begin
        if (load) base[load_slot] <= addr;
    end

    assign base_sel = base[beat_slot];
    assign waddr    = {base_sel[AW-1:BEAT_W], base_sel[BEAT_W-1:0] + beat_idx};

    // Store the enabled byte lanes of the current write beat.
    always_ff @(posedge clk) begin
        if (beat_vld) begin
            for (int l = 0; l < NB; l++) begin
                if (!byte_wr_n[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    // Gather the four burst words in wrap order for a read snapshot.
    always_comb begin
        for (int i = 0; i < BURST_LEN; i++) begin
            snap_words[i] = mem[{addr[AW-1:BEAT_W], addr[BEAT_W-1:0] + BEAT_W'(i)}];
        end
    end
endmodule

// File: rtl/qdr4_rd_buf.sv
// Read burst buffer and output register. Each read slot holds the four words
// captured when its read was accepted. The output register puts one word per
// half-period on rdata and raises drive. When no beat is due, the bus reads
// zero with drive low. Assumes at most one read beat per edge.
module qdr4_rd_buf
    import qdr4_pkg::*;
#(
    parameter  int DW     = 16,
    parameter  int SLOTS  = 2,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [SLOT_W-1:0]            load_slot,
    input  logic [BURST_LEN-1:0][DW-1:0] load_words,
    input  logic                         beat_vld,
    input  logic [SLOT_W-1:0]            beat_slot,
    input  beat_t                        beat_idx,
    output logic [DW-1:0]                rdata,
    output logic                         drive
);
    logic [BURST_LEN-1:0][DW-1:0] words [SLOTS];

    // Hold the words of an accepted read until its beats are sent.
    always_ff @(posedge clk) begin
        if (load) words[load_slot] <= load_words;
    end

    // Present the due beat, or release the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive <= 1'b0;
            rdata <= '0;
        end else if (beat_vld) begin
            drive <= 1'b1;
            rdata <= words[beat_slot][beat_idx];
        end else begin
            drive <= 1'b0;
            rdata <= '0;
        end
    end
endmodule

// File: rtl/qdr4_burst_sram.sv
// Top of the burst-of-four quad-data-rate memory model. Builds the phase
// tracker, one request gate and one burst sequencer per port, the array and
// the read buffer. Assumes clk is twice the K rate; see k_phase for alignment.
module qdr4_burst_sram
    import qdr4_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_sel_n,
    input  logic          wr_sel_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] byte_wr_n,
    output logic [DW-1:0] rdata,
    output logic          rdata_drive,
    output logic          k_phase
);
    localparam int SLOT_W = (PORT_SLOTS > 1) ? $clog2(PORT_SLOTS) : 1;

    logic                         k_next;
    logic                         rd_acc, wr_acc;
    logic [SLOT_W-1:0]            r_acc_slot, w_acc_slot;
    logic                         r_beat_vld, w_beat_vld;
    logic [SLOT_W-1:0]            r_beat_slot, w_beat_slot;
    beat_t                        r_beat_idx, w_beat_idx;
    logic [BURST_LEN-1:0][DW-1:0] snap_words;

    assign k_phase = k_next;

    qdr4_phase_gen u_phase (.clk(clk), .rst_n(rst_n), .k_next(k_next));

    qdr4_req_gate u_rd_gate (.clk(clk), .rst_n(rst_n), .k_edge(k_next), .sel_n(rd_sel_n), .accept(rd_acc));
    qdr4_req_gate u_wr_gate (.clk(clk), .rst_n(rst_n), .k_edge(k_next), .sel_n(wr_sel_n), .accept(wr_acc));

    qdr4_burst_seq #(.FIRST_HALF(WR_FIRST_HALF), .SLOTS(PORT_SLOTS)) u_wr_seq (
        .clk(clk), .rst_n(rst_n), .accept(wr_acc), .acc_slot(w_acc_slot),
        .beat_vld(w_beat_vld), .beat_slot(w_beat_slot), .beat_idx(w_beat_idx)
    );

    qdr4_burst_seq #(.FIRST_HALF(RD_FIRST_HALF), .SLOTS(PORT_SLOTS)) u_rd_seq (
        .clk(clk), .rst_n(rst_n), .accept(rd_acc), .acc_slot(r_acc_slot),
        .beat_vld(r_beat_vld), .beat_slot(r_beat_slot), .beat_idx(r_beat_idx)
    );

    qdr4_array #(.AW(AW), .DW(DW), .NB(NB), .SLOTS(PORT_SLOTS)) u_array (
        .clk(clk), .load(wr_acc), .load_slot(w_acc_slot), .addr(addr),
        .beat_vld(w_beat_vld), .beat_slot(w_beat_slot), .beat_idx(w_beat_idx),
        .wdata(wdata), .byte_wr_n(byte_wr_n), .snap_words(snap_words)
    );

    qdr4_rd_buf #(.DW(DW), .SLOTS(PORT_SLOTS)) u_rd_buf (
        .clk(clk), .rst_n(rst_n), .load(rd_acc), .load_slot(r_acc_slot),
        .load_words(snap_words), .beat_vld(r_beat_vld), .beat_slot(r_beat_slot),
        .beat_idx(r_beat_idx), .rdata(rdata), .drive(rdata_drive)
    );
endmodule

// File: rtl/qdr4_burst_sram_chk.sv
// Property checker for qdr4_burst_sram, attached with bind. Watches the
// ports plus the per-port accept strobes and the array write strobe.
module qdr4_burst_sram_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_sel_n,
    input logic          wr_sel_n,
    input logic          k_phase,
    input logic          rdata_drive,
    input logic [DW-1:0] rdata,
    input logic          mem_we,
    input logic          rd_acc,
    input logic          wr_acc
);
    AST_WRITE_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(!wr_sel_n && k_phase, 2) || $past(!wr_sel_n && k_phase, 3) ||
                    $past(!wr_sel_n && k_phase, 4) || $past(!wr_sel_n && k_phase, 5))); // R1

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_drive) |-> $past(!rd_sel_n && k_phase, 6)); // R2

    AST_FIRST_BEAT_ON_KSHARP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_drive) |-> k_phase); // R2

    AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> ##2 !rd_acc); // R5

    AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> ##2 !wr_acc); // R5

    AST_ACCEPT_ON_K: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc || wr_acc) |-> k_phase); // R8

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_drive |-> rdata == '0); // R10

    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> k_phase != $past(k_phase)); // R12
endmodule

bind qdr4_burst_sram qdr4_burst_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .k_phase(k_phase), .rdata_drive(rdata_drive), .rdata(rdata),
    .mem_we(w_beat_vld), .rd_acc(rd_acc), .wr_acc(wr_acc)
);

// File: tb/sim_qdr4_burst_sram.sv
// Directed bench for qdr4_burst_sram: one task per scenario, each checking
// its own results against a bench-side memory model.
module sim_qdr4_burst_sram;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NB = 2;
    localparam int NH = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_sel_n, wr_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [NB-1:0] byte_wr_n;
    logic [DW-1:0] rdata;
    logic          rdata_drive;
    logic          k_phase;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic          sch_rd [NH];
    logic          sch_wr [NH];
    logic [AW-1:0] sch_addr [NH];
    logic [DW-1:0] sch_wd [NH];
    logic [NB-1:0] sch_bm [NH];
    logic          cap_drv [NH];
    logic [DW-1:0] cap_data [NH];
    logic          cap_ph [NH];
    logic [DW-1:0] mdl [1<<AW];
    logic [DW-1:0] tw [4];
    logic [NB-1:0] tm [4];

    always #5 clk = ~clk;

    qdr4_burst_sram #(.AW(AW), .DW(DW), .NB(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wdata(wdata), .byte_wr_n(byte_wr_n),
        .rdata(rdata), .rdata_drive(rdata_drive), .k_phase(k_phase)
    );

    function automatic logic [AW-1:0] baddr(input logic [AW-1:0] a, input int i);
        return {a[AW-1:2], 2'(a[1:0] + i)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_sched();
        for (int h = 0; h < NH; h++) begin
            sch_rd[h] = 0; sch_wr[h] = 0; sch_addr[h] = '0;
            sch_wd[h] = 16'hBEEF ^ DW'(h * 16'h0101); sch_bm[h] = '0;
        end
    endtask

    task automatic sched_read(input int h, input logic [AW-1:0] a);
        sch_rd[h] = 1; sch_addr[h] = a;
    endtask

    task automatic sched_write(input int h, input logic [AW-1:0] a);
        sch_wr[h] = 1; sch_addr[h] = a;
        for (int i = 0; i < 4; i++) begin
            sch_wd[h+2+i] = tw[i]; sch_bm[h+2+i] = tm[i];
        end
    endtask

    task automatic mdl_write(input logic [AW-1:0] a);
        for (int i = 0; i < 4; i++)
            for (int l = 0; l < NB; l++)
                if (!tm[i][l]) mdl[baddr(a, i)][l*8 +: 8] = tw[i][l*8 +: 8];
    endtask

    task automatic idle_inputs();
        rd_sel_n = 1; wr_sel_n = 1; addr = '0; wdata = '0; byte_wr_n = '1;
    endtask

    // Align to a K rise, play the schedule, capture outputs after each edge.
    task automatic run(input int n);
        @(negedge clk);
        while (!k_phase) @(negedge clk);
        for (int h = 0; h < n; h++) begin
            rd_sel_n = !sch_rd[h]; wr_sel_n = !sch_wr[h]; addr = sch_addr[h];
            wdata = sch_wd[h]; byte_wr_n = sch_bm[h];
            @(negedge clk);
            cap_drv[h] = rdata_drive; cap_data[h] = rdata; cap_ph[h] = k_phase;
        end
        idle_inputs();
    endtask

    task automatic check_burst(input int h0, input logic [AW-1:0] a, input string req);
        for (int i = 0; i < 4; i++) begin
            chk({req, " drive"}, 32'(cap_drv[h0+5+i]), 32'd1);
            chk({req, " data"}, 32'(cap_data[h0+5+i]), 32'(mdl[baddr(a, i)]));
        end
    endtask

    task automatic t_reset();
        chk("R6 k_phase", 32'(k_phase), 32'd1);
        chk("R6 drive", 32'(rdata_drive), 32'd0);
        chk("R6 rdata", 32'(rdata), 32'd0);
    endtask

    task automatic t_fill();
        clear_sched();
        for (int g = 0; g < 4; g++) begin
            for (int i = 0; i < 4; i++) begin
                tw[i] = 16'hC000 | DW'((g*4+i) * 16'h0111); tm[i] = '0;
            end
            sched_write(g*4, AW'(g*4));
            mdl_write(AW'(g*4));
        end
        run(20);
    endtask

    task automatic t_latency();
        clear_sched(); sched_read(0, 4); run(12);
        chk("R2 idle before h5", 32'(cap_drv[4]), 32'd0);
        check_burst(0, 4, "R1 R2");
        chk("R2 idle after h8", 32'(cap_drv[9]), 32'd0);
        for (int h = 0; h < 12; h++) chk("R12 phase", 32'(cap_ph[h]), 32'(h % 2));
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 4; i++) begin tw[i] = 16'h6A00 + DW'(i); tm[i] = '0; end
        clear_sched(); sched_write(0, 6); run(10); mdl_write(6);
        chk("R3 wrapped word", 32'(mdl[4]), 32'h6A02);
        clear_sched(); sched_read(0, 6); sched_read(4, 4); run(16);
        check_burst(0, 6, "R3");
        check_burst(4, 4, "R3");
    endtask

    task automatic t_bytes();
        for (int i = 0; i < 4; i++) tw[i] = 16'h7700 + DW'(i * 16'h1111);
        tm[0] = 2'b10; tm[1] = 2'b01; tm[2] = 2'b11; tm[3] = 2'b00;
        clear_sched(); sched_write(0, 8); run(10); mdl_write(8);
        clear_sched(); sched_read(0, 8); run(12);
        check_burst(0, 8, "R4");
    endtask

    task automatic t_b2b_read();
        clear_sched(); sched_read(0, 0); sched_read(2, 12); sched_read(4, 4); run(16);
        check_burst(0, 0, "R5 first");
        check_burst(4, 4, "R5 third");
        chk("R5 no extra beat", 32'(cap_drv[13]), 32'd0);
    endtask

    task automatic t_b2b_write();
        for (int i = 0; i < 4; i++) begin tw[i] = 16'h5C00 + DW'(i); tm[i] = '0; end
        clear_sched(); sched_write(0, 12); sch_wr[2] = 1; sch_addr[2] = 0; run(10);
        mdl_write(12);
        clear_sched(); sched_read(0, 0); sched_read(4, 12); run(16);
        check_burst(0, 0, "R5 ignored write");
        check_burst(4, 12, "R5 kept write");
    endtask

    task automatic t_pipe();
        clear_sched(); sched_read(0, 8); sched_read(4, 0); run(16);
        chk("R11 idle before", 32'(cap_drv[4]), 32'd0);
        check_burst(0, 8, "R11");
        check_burst(4, 0, "R11");
        chk("R11 idle after", 32'(cap_drv[13]), 32'd0);
    endtask

    task automatic t_kbar();
        clear_sched(); sch_rd[1] = 1; sch_wr[1] = 1; sch_addr[1] = 12; run(14);
        for (int h = 0; h < 14; h++) chk("R8 no read", 32'(cap_drv[h]), 32'd0);
        clear_sched(); sched_read(0, 12); run(12);
        check_burst(0, 12, "R8 no write");
    endtask

    task automatic t_same();
        for (int i = 0; i < 4; i++) begin tw[i] = 16'h9900 + DW'(i); tm[i] = '0; end
        clear_sched(); sched_write(0, 0); sched_read(0, 0); run(12);
        check_burst(0, 0, "R9 old data");
        mdl_write(0);
        clear_sched(); sched_read(0, 0); run(12);
        check_burst(0, 0, "R9 new data");
    endtask

    task automatic t_nop();
        clear_sched(); run(12);
        for (int h = 0; h < 12; h++) begin
            chk("R7 drive", 32'(cap_drv[h]), 32'd0);
            chk("R10 rdata", 32'(cap_data[h]), 32'd0);
        end
        clear_sched(); sched_read(0, 4); run(12);
        check_burst(0, 4, "R7 array unchanged");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_latency();
        t_wrap();
        t_bytes();
        t_b2b_read();
        t_b2b_write();
        t_pipe();
        t_kbar();
        t_same();
        t_nop();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule